// File: doc/BRIEF.md
# Extended Private Interrupt Active-State Clear Slice

This block is one per-core slice that keeps the active state of up to 64 extended private interrupts. Interrupt sources raise a bit by pulsing the matching activate input. Software sees the state through two 32-bit write-one-to-clear windows on a simple memory-mapped register bus. A read returns the active bits. Writing a one to a bit deactivates that interrupt.

Every bit is filtered on both the read path and the write path. A bit is only visible and clearable when all of these hold: its interrupt is implemented, affinity routing is on, and the access is allowed to touch it. A non-secure access may not touch interrupts that belong to the secure group unless security is disabled globally. Bits that are filtered out read as zero and ignore writes. Read data is registered.

Top module: `ext_active_clr`

## Requirements
- R1: After a synchronous reset all 64 active bits are zero and `rd_data` is zero.
- R2: Window 1 is decoded at byte offset 0x384 and holds interrupt bits 0..31 (window bit k is interrupt k). Window 2 is decoded at 0x388 and holds interrupt bits 32..63 (window bit k is interrupt 32+k). A read of any other offset returns zero, and a write to any other offset changes nothing.
- R3: `rd_data` shows the filtered active bits of the addressed window on the cycle after `rd_en` is high. It is zero on the cycle after `rd_en` is low.
- R4: A one on `act_pulse[i]` sets active bit i on the next clock edge. The bit then stays set until it is cleared.
- R5: Writing a one to a visible bit clears its active state. A written zero leaves the bit unchanged. Writing a one to a bit that is already inactive leaves it inactive.
- R6: A bit whose `impl_mask` bit is zero reads as zero and ignores writes.
- R7: When `sec_off` is 0 and `bus_secure` is 0, bits whose `grp_secure` bit is 1 read as zero and ignore writes. A secure access, or any access while `sec_off` is 1, reads and clears every implemented bit.
- R8: While `affinity_on` is 0, both windows read as zero and writes change nothing.
- R9: When an activate pulse and a clearing write hit the same bit in the same cycle, the bit ends up inactive.
- R10: When a read and a write address the same window in the same cycle, the read returns the state from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset within the register frame |
| bus_wdata | input | 32 | Write data, ones clear active bits |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| bus_secure | input | 1 | High for a secure access |
| rd_data | output | 32 | Registered read data |
| act_pulse | input | 64 | Per-interrupt activate pulse |
| impl_mask | input | 64 | Per-interrupt implemented flag |
| grp_secure | input | 64 | Per-interrupt secure-group flag |
| sec_off | input | 1 | Global security disable |
| affinity_on | input | 1 | Affinity routing enable |

## Verification
An activate pulse or a clearing write that is sampled on one edge changes the active state at that same edge. That change appears in read data only through a read issued on a later cycle. Read data itself is due exactly one edge after its read strobe. The bench drives and samples on falling edges. It runs a behavioural model that updates on each rising edge with the same timing, and it compares `rd_data` against the model at every falling edge, so each result is checked in the one cycle where it is due.

// File: rtl/xact_pkg.sv
package xact_pkg;
    localparam int VIEW_W    = 32;
    localparam int NUM_VIEWS = 2;
    localparam int TOTAL     = VIEW_W * NUM_VIEWS;
    localparam int ADDR_W    = 12;
    localparam int BASE_OFF  = 'h380;
    localparam int IDX_W     = (NUM_VIEWS > 1) ? $clog2(NUM_VIEWS) : 1;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } win_sel_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [VIEW_W-1:0] wdata;
        logic              we;
        logic              re;
        logic              secure;
    } bus_req_t;

    // Window n (1-based) lives at BASE_OFF + 4*n.
    function automatic win_sel_t decode_win(input logic [ADDR_W-1:0] addr);
        win_sel_t s;
        s = '0;
        for (int n = 1; n <= NUM_VIEWS; n++) begin
            if (addr == ADDR_W'(BASE_OFF + 4 * n)) begin
                s.hit = 1'b1;
                s.idx = IDX_W'(n - 1);
            end
        end
        return s;
    endfunction
endpackage

// File: rtl/xact_decode.sv
module xact_decode
    import xact_pkg::*;
(
    input  bus_req_t req,
    output win_sel_t sel,
    output logic     wr_hit,
    output logic     rd_hit
);
    always_comb begin
        sel    = decode_win(req.addr);
        wr_hit = req.we & sel.hit;
        rd_hit = req.re & sel.hit;
    end
endmodule

// File: rtl/xact_filter.sv
module xact_filter #(
    parameter int N = 64
) (
    input  logic [N-1:0] impl_mask,
    input  logic [N-1:0] grp_secure,
    input  logic         sec_off,
    input  logic         affinity_on,
    input  logic         acc_secure,
    output logic [N-1:0] access_ok
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign access_ok[i] = affinity_on & impl_mask[i]
                            & (acc_secure | sec_off | ~grp_secure[i]);
    end
endmodule

// File: rtl/xact_bank.sv
module xact_bank #(
    parameter int W = 32,
    parameter int V = 2,
    localparam int N = W * V
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] active_q
);
    for (genvar v = 0; v < V; v++) begin : g_view
        always_ff @(posedge clk) begin
            if (rst) begin
                active_q[v*W +: W] <= '0;
            end else begin
                // Clearing has priority over a same-cycle activation.
                active_q[v*W +: W] <= (active_q[v*W +: W] | set_vec[v*W +: W])
                                      & ~clr_vec[v*W +: W];
            end
        end
    end
endmodule

// File: rtl/ext_active_clr.sv
module ext_active_clr
    import xact_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [VIEW_W-1:0] bus_wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              bus_secure,
    output logic [VIEW_W-1:0] rd_data,
    input  logic [TOTAL-1:0]  act_pulse,
    input  logic [TOTAL-1:0]  impl_mask,
    input  logic [TOTAL-1:0]  grp_secure,
    input  logic              sec_off,
    input  logic              affinity_on
);
    bus_req_t          req;
    win_sel_t          sel;
    logic              wr_hit, rd_hit;
    logic [TOTAL-1:0]  access_ok;
    logic [TOTAL-1:0]  clr_vec;
    logic [TOTAL-1:0]  active_q;
    logic [VIEW_W-1:0] view_rd [NUM_VIEWS];
    logic [VIEW_W-1:0] rd_sel;
    logic [VIEW_W-1:0] rd_q;

    assign req = '{addr: bus_addr, wdata: bus_wdata, we: wr_en,
                   re: rd_en, secure: bus_secure};

    xact_decode u_decode (
        .req    (req),
        .sel    (sel),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    xact_filter #(.N(TOTAL)) u_filter (
        .impl_mask   (impl_mask),
        .grp_secure  (grp_secure),
        .sec_off     (sec_off),
        .affinity_on (affinity_on),
        .acc_secure  (req.secure),
        .access_ok   (access_ok)
    );

    for (genvar v = 0; v < NUM_VIEWS; v++) begin : g_win
        assign clr_vec[v*VIEW_W +: VIEW_W] =
            (wr_hit && sel.idx == IDX_W'(v)) ? (req.wdata & access_ok[v*VIEW_W +: VIEW_W])
                                              : '0;
        assign view_rd[v] = active_q[v*VIEW_W +: VIEW_W] & access_ok[v*VIEW_W +: VIEW_W];
    end

    xact_bank #(.W(VIEW_W), .V(NUM_VIEWS)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (act_pulse),
        .clr_vec  (clr_vec),
        .active_q (active_q)
    );

    assign rd_sel = view_rd[sel.idx];

    always_ff @(posedge clk) begin
        if (rst)         rd_q <= '0;
        else if (rd_hit) rd_q <= rd_sel;
        else             rd_q <= '0;
    end

    assign rd_data = rd_q;

    // R3: an idle read strobe yields zero data one cycle later
    p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> rd_data == '0);

    // R4: an activation not cleared in the same cycle lands in state
    p_act_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (act_pulse & ~clr_vec) != '0 |=>
        (active_q & $past(act_pulse & ~clr_vec)) == $past(act_pulse & ~clr_vec));

    // R5: the bus never sets a bit; only activation pulses do
    p_no_bus_set_r5: assert property (@(posedge clk) disable iff (rst)
        act_pulse == '0 |=> (active_q & ~$past(active_q)) == '0);

    // R6: bits outside the access mask are never cleared by a write
    p_masked_hold_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ($past(active_q) & ~$past(access_ok) & ~active_q) == '0);

    // R8: reads with affinity routing off return zero
    p_aff_off_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !affinity_on) |=> rd_data == '0);

    // R9: a clearing write beats a same-cycle activation
    p_clear_wins_r9: assert property (@(posedge clk) disable iff (rst)
        clr_vec != '0 |=> (active_q & $past(clr_vec)) == '0);
endmodule

// File: tb/test_ext_active_clr.sv
module test_ext_active_clr;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0, bus_secure = 1'b1;
    logic [31:0] rd_data;
    logic [63:0] act_pulse = '0, impl_mask = '1, grp_secure = '0;
    logic        sec_off = 1'b1, affinity_on = 1'b1;

    int    checks = 0, errors = 0, cycles = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    logic [63:0] m_act;
    logic [31:0] m_rd;

    always #10 clk = ~clk;

    ext_active_clr i_ext_active_clr (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .wr_en(wr_en), .rd_en(rd_en), .bus_secure(bus_secure), .rd_data(rd_data),
        .act_pulse(act_pulse), .impl_mask(impl_mask), .grp_secure(grp_secure),
        .sec_off(sec_off), .affinity_on(affinity_on)
    );

    function automatic bit visible(int i);
        return affinity_on && impl_mask[i] && (bus_secure || sec_off || !grp_secure[i]);
    endfunction

    function automatic int win_of(logic [11:0] a);
        if (a == 12'h384) return 0;
        if (a == 12'h388) return 1;
        return -1;
    endfunction

    // Behavioural reference, updated on the rising edge
    always @(posedge clk) begin
        logic [63:0] nxt;
        logic [31:0] rd;
        int w;
        if (rst) begin
            m_act <= '0;
            m_rd  <= '0;
        end else begin
            w  = win_of(bus_addr);
            rd = '0;
            if (rd_en && w >= 0)
                for (int k = 0; k < 32; k++)
                    rd[k] = m_act[w*32+k] && visible(w*32+k);
            nxt = m_act;
            for (int i = 0; i < 64; i++) begin
                if (act_pulse[i]) nxt[i] = 1'b1;
                if (wr_en && w == i / 32 && bus_wdata[i % 32] && visible(i)) nxt[i] = 1'b0;
            end
            m_act <= nxt;
            m_rd  <= rd;
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (!done) begin
            checks++;
            if (rd_data !== m_rd) begin
                errors++;
                $display("FAIL %s rd_data actual %h expected %h at cycle %0d",
                         cur_req, rd_data, m_rd, cycles);
            end
        end
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog actual %0d expected below 20000 cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic op(input logic [11:0] a, input logic [31:0] d,
                      input logic we, input logic re, input logic [63:0] act = '0);
        bus_addr = a; bus_wdata = d; wr_en = we; rd_en = re; act_pulse = act;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; act_pulse = '0;
    endtask

    task automatic rd(input logic [11:0] a);
        op(a, '0, 1'b0, 1'b1);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        op(a, d, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_req = "R1"; rd(12'h384); rd(12'h388); op(0, 0, 0, 0);

        cur_req = "R4";
        op(0, 0, 0, 0, 64'h8000_0001_8000_0021);
        rd(12'h384); rd(12'h388); op(0, 0, 0, 0);

        cur_req = "R5";
        wr(12'h384, 32'h0); rd(12'h384);
        wr(12'h384, 32'h20); rd(12'h384);
        wr(12'h384, 32'h20); rd(12'h384); op(0, 0, 0, 0);

        cur_req = "R2";
        wr(12'h380, '1); wr(12'h38C, '1); wr(12'h385, '1);
        rd(12'h380); rd(12'h38C); rd(12'h384); rd(12'h388);
        wr(12'h388, 32'h1); rd(12'h388); rd(12'h384); op(0, 0, 0, 0);

        cur_req = "R6";
        impl_mask[0] = 1'b0;
        rd(12'h384); wr(12'h384, 32'h1); rd(12'h384);
        impl_mask[0] = 1'b1;
        rd(12'h384); op(0, 0, 0, 0);

        cur_req = "R7";
        grp_secure = 64'h8000_0000_8000_0000;
        sec_off = 1'b0; bus_secure = 1'b0;
        rd(12'h384); rd(12'h388);
        wr(12'h384, 32'h8000_0000); rd(12'h384);
        bus_secure = 1'b1; rd(12'h384); rd(12'h388);
        bus_secure = 1'b0; sec_off = 1'b1; rd(12'h388);
        wr(12'h388, 32'h8000_0000); rd(12'h388);
        sec_off = 1'b0; bus_secure = 1'b1;
        wr(12'h384, 32'h8000_0000); rd(12'h384); op(0, 0, 0, 0);

        cur_req = "R8";
        op(0, 0, 0, 0, 64'h0000_00F0_0000_00F0);
        affinity_on = 1'b0;
        rd(12'h384); wr(12'h384, '1); wr(12'h388, '1); rd(12'h388);
        affinity_on = 1'b1;
        rd(12'h384); rd(12'h388); op(0, 0, 0, 0);

        cur_req = "R9";
        op(12'h384, 32'h400, 1'b1, 1'b0, 64'h0000_0000_0000_0400);
        rd(12'h384); op(0, 0, 0, 0);

        cur_req = "R10";
        op(0, 0, 0, 0, 64'h8);
        op(12'h384, 32'h8, 1'b1, 1'b1);
        rd(12'h384); op(0, 0, 0, 0);

        cur_req = "R3";
        for (int n = 0; n < 400; n++) begin
            logic [11:0] a;
            a = ($urandom_range(0, 3) == 0) ? 12'h38C : (($urandom_range(0, 1) == 0) ? 12'h384 : 12'h388);
            bus_secure  = 1'($urandom_range(0, 1));
            sec_off     = 1'($urandom_range(0, 1));
            affinity_on = ($urandom_range(0, 7) != 0);
            impl_mask   = {$urandom, $urandom} | {$urandom, $urandom};
            grp_secure  = {$urandom, $urandom};
            op(a, $urandom & $urandom, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               {$urandom, $urandom} & {$urandom, $urandom});
        end
        op(0, 0, 0, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule